// File: doc/BRIEF.md
# I2C Line State and Collision Monitor

This block sits beside the shift register of a serial port that can run either as a plain port or as a two-wire I2C-style controller. It watches the raw clock and data lines through synchronizers. It reports START and STOP conditions as single-cycle pulses and keeps a bus-busy flag while the bus is claimed. It compares the bit the port is driving with the level it reads back, and records a lost arbitration in a flag that software clears.

Three options are set by control inputs. The first chooses when the comparison takes place: on a rising edge of the transfer clock, or when the synchronized data line falls. The second chooses whether the arbitration flag follows each bit, or is set only when a byte completes. The third lets a collision drop the transmit enable on its own. A further input chooses what launches a transmission: a software request or a timer underflow pulse. All control inputs come from registers that reset to 0.

Top module: `i2c_line_monitor`

## Requirements
- R1: A START (synchronized data falling while synchronized clock is high) sets `bus_busy`, and a STOP (data rising while clock is high) clears it. A data edge while the clock is low leaves `bus_busy` unchanged. `bus_busy` changes on the third clock edge after the raw line change, with the default two synchronizer stages.
- R2: A collision event occurs at a sample instant where `drv_bit` is 1 and the synchronized data line is 0. At an instant with no such mismatch, `arb_lost` is not set.
- R3: With `coll_sel`=0 the sample instant is a rising edge of `xfer_clk`. With `coll_sel`=1 it is a falling edge of the synchronized data line, and rising edges of `xfer_clk` do not sample.
- R4: With `abt_gran`=0, `arb_lost` is set on the clock edge at which the collision event is present.
- R5: With `abt_gran`=1, a collision is held internally and `arb_lost` stays 0 until a `byte_done` pulse, which sets it.
- R6: `arb_clr` clears `arb_lost`. When a collision sets the flag in the same cycle, the set wins.
- R7: With `autoclr_en`=1, a collision event clears `txen`, even against a same-cycle `txen_wr` of 1. With `autoclr_en`=0, a collision leaves `txen` unchanged.
- R8: `tx_start` is a one-cycle pulse one clock after the trigger. The trigger is `tx_go` when `tx_trig_sel`=0 and `tmr_uflow` when `tx_trig_sel`=1. The unselected source is ignored, and no pulse occurs while `txen`=0.
- R9: With `i2c_mode`=0, `bus_busy` is held 0 and no START or STOP pulse is produced.
- R10: After reset, `bus_busy`, `arb_lost`, `txen`, `tx_start`, `start_det` and `stop_det` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_line | input | 1 | Raw serial clock line |
| sda_line | input | 1 | Raw serial data line |
| i2c_mode | input | 1 | 1 enables START/STOP tracking |
| coll_sel | input | 1 | Collision sample point: 0 transfer clock rise, 1 data fall |
| abt_gran | input | 1 | Arbitration flag update: 0 per bit, 1 per byte |
| autoclr_en | input | 1 | 1 lets a collision clear `txen` |
| tx_trig_sel | input | 1 | Transmit trigger: 0 `tx_go`, 1 `tmr_uflow` |
| xfer_clk | input | 1 | Transfer clock level, synchronous to `clk` |
| drv_bit | input | 1 | Data bit being driven (1 = released) |
| byte_done | input | 1 | Pulse when the eighth bit of a byte completes |
| arb_clr | input | 1 | Software clear of `arb_lost` |
| txen_wr | input | 1 | Software write strobe for `txen` |
| txen_wdata | input | 1 | Value written to `txen` |
| tx_go | input | 1 | Software transmit request pulse |
| tmr_uflow | input | 1 | Timer underflow pulse |
| start_det | output | 1 | START condition pulse |
| stop_det | output | 1 | STOP condition pulse |
| bus_busy | output | 1 | Bus claimed between START and STOP |
| arb_lost | output | 1 | Arbitration lost flag |
| txen | output | 1 | Transmit enable |
| tx_start | output | 1 | Transmit start strobe |

## Verification
The assertions check every cycle that a START or STOP pulse moves the busy flag, that busy stays low with the mode off, and that a per-bit collision sets the flag. They also check that the flag cannot rise in per-byte mode without a byte boundary, that an auto-clear collision drops the enable, and that a start strobe appears only after the enable was high. Only the bench's scenarios can show the rest. These include the exact synchronizer latency, the sample instant that each `coll_sel` value ignores, and the data edges with the clock low that must not be read as conditions. They also include the priority of set over clear and of auto-clear over a software write, and the suppression of the unselected trigger source.

// File: rtl/ilm_pkg.sv
package ilm_pkg;
   localparam logic LINE_IDLE = 1'b1;

   typedef enum logic {
      SAMPLE_XCLK_RISE = 1'b0,
      SAMPLE_SDA_FALL  = 1'b1
   } ilm_sample_e;

   typedef enum logic {
      GRAN_BIT  = 1'b0,
      GRAN_BYTE = 1'b1
   } ilm_gran_e;

   typedef enum logic {
      TRIG_SW  = 1'b0,
      TRIG_TMR = 1'b1
   } ilm_trig_e;
endpackage

// File: rtl/ilm_sync.sv
module ilm_sync #(
   parameter int   STAGES  = 2,
   parameter int   WIDTH   = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN = STAGES * WIDTH;

   if (STAGES < 2) begin : g_bad_stages
      $error("ilm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ilm_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {CHAIN{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ilm_bus_cond.sv
module ilm_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic i2c_mode,
   input  logic scl_s,
   input  logic sda_s,
   output logic sda_fall,
   output logic start_det,
   output logic stop_det,
   output logic bus_busy
);
   logic sda_d;
   logic sda_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_d <= ilm_pkg::LINE_IDLE;
      else        sda_d <= sda_s;
   end

   assign sda_fall  = sda_d & ~sda_s;
   assign sda_rise  = ~sda_d & sda_s;
   assign start_det = i2c_mode & scl_s & sda_fall;
   assign stop_det  = i2c_mode & scl_s & sda_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_busy <= 1'b0;
      else if (!i2c_mode) bus_busy <= 1'b0;
      else if (start_det) bus_busy <= 1'b1;
      else if (stop_det)  bus_busy <= 1'b0;
   end

   // R1
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> bus_busy);
   // R1
   busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !bus_busy);
   // R9
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_mode |=> !bus_busy);
endmodule

// File: rtl/ilm_collide.sv
module ilm_collide (
   input  logic clk,
   input  logic rst_n,
   input  logic coll_sel,
   input  logic abt_gran,
   input  logic xfer_clk,
   input  logic drv_bit,
   input  logic sda_s,
   input  logic sda_fall,
   input  logic byte_done,
   input  logic arb_clr,
   output logic coll_ev,
   output logic arb_lost
);
   import ilm_pkg::*;

   logic xclk_d;
   logic strobe;
   logic pend;
   logic set_flag;
   logic per_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) xclk_d <= 1'b0;
      else        xclk_d <= xfer_clk;
   end

   assign strobe   = (ilm_sample_e'(coll_sel) == SAMPLE_SDA_FALL) ? sda_fall
                                                                  : (xfer_clk & ~xclk_d);
   assign coll_ev  = strobe & drv_bit & ~sda_s;
   assign per_byte = (ilm_gran_e'(abt_gran) == GRAN_BYTE);
   assign set_flag = per_byte ? (byte_done & (pend | coll_ev)) : coll_ev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend <= 1'b0;
      else if (!per_byte) pend <= 1'b0;
      else if (byte_done) pend <= 1'b0;
      else if (coll_ev)   pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        arb_lost <= 1'b0;
      else if (set_flag) arb_lost <= 1'b1;
      else if (arb_clr)  arb_lost <= 1'b0;
   end

   // R4
   bit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_ev && !abt_gran) |=> arb_lost);
   // R5
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (abt_gran && !byte_done && !arb_lost) |=> !arb_lost);
   // R6
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_clr && !abt_gran && !coll_ev) |=> !arb_lost);
endmodule

// File: rtl/ilm_txctl.sv
module ilm_txctl (
   input  logic clk,
   input  logic rst_n,
   input  logic autoclr_en,
   input  logic tx_trig_sel,
   input  logic coll_ev,
   input  logic txen_wr,
   input  logic txen_wdata,
   input  logic tx_go,
   input  logic tmr_uflow,
   output logic txen,
   output logic tx_start
);
   import ilm_pkg::*;

   logic trig;

   assign trig = (ilm_trig_e'(tx_trig_sel) == TRIG_TMR) ? tmr_uflow : tx_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      txen <= 1'b0;
      else if (autoclr_en && coll_ev)  txen <= 1'b0;
      else if (txen_wr)                txen <= txen_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_start <= 1'b0;
      else        tx_start <= txen & trig;
   end

   // R7
   autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (autoclr_en && coll_ev) |=> !txen);
   // R7
   txen_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!autoclr_en && !txen_wr) |=> $stable(txen));
   // R8
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> $past(txen));
endmodule

// File: rtl/i2c_line_monitor.sv
module i2c_line_monitor #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_line,
   input  logic sda_line,
   input  logic i2c_mode,
   input  logic coll_sel,
   input  logic abt_gran,
   input  logic autoclr_en,
   input  logic tx_trig_sel,
   input  logic xfer_clk,
   input  logic drv_bit,
   input  logic byte_done,
   input  logic arb_clr,
   input  logic txen_wr,
   input  logic txen_wdata,
   input  logic tx_go,
   input  logic tmr_uflow,
   output logic start_det,
   output logic stop_det,
   output logic bus_busy,
   output logic arb_lost,
   output logic txen,
   output logic tx_start
);
   localparam int LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2c_line_monitor: SYNC_STAGES must be at least 2");
   end

   logic [LINES-1:0] lines_s;
   logic             sda_fall;
   logic             coll_ev;

   ilm_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (LINES),
      .RST_VAL(ilm_pkg::LINE_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({scl_line, sda_line}),
      .q    (lines_s)
   );

   ilm_bus_cond u_cond (
      .clk      (clk),
      .rst_n    (rst_n),
      .i2c_mode (i2c_mode),
      .scl_s    (lines_s[1]),
      .sda_s    (lines_s[0]),
      .sda_fall (sda_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .bus_busy (bus_busy)
   );

   ilm_collide u_coll (
      .clk      (clk),
      .rst_n    (rst_n),
      .coll_sel (coll_sel),
      .abt_gran (abt_gran),
      .xfer_clk (xfer_clk),
      .drv_bit  (drv_bit),
      .sda_s    (lines_s[0]),
      .sda_fall (sda_fall),
      .byte_done(byte_done),
      .arb_clr  (arb_clr),
      .coll_ev  (coll_ev),
      .arb_lost (arb_lost)
   );

   ilm_txctl u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .autoclr_en (autoclr_en),
      .tx_trig_sel(tx_trig_sel),
      .coll_ev    (coll_ev),
      .txen_wr    (txen_wr),
      .txen_wdata (txen_wdata),
      .tx_go      (tx_go),
      .tmr_uflow  (tmr_uflow),
      .txen       (txen),
      .tx_start   (tx_start)
   );

   // R9
   no_cond_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_mode |-> !(start_det || stop_det));
endmodule

// File: tb/i2c_line_monitor_tb_top.sv
module i2c_line_monitor_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_line = 1'b1, sda_line = 1'b1;
   logic i2c_mode = 1'b0, coll_sel = 1'b0, abt_gran = 1'b0, autoclr_en = 1'b0;
   logic tx_trig_sel = 1'b0, xfer_clk = 1'b0, drv_bit = 1'b0, byte_done = 1'b0;
   logic arb_clr = 1'b0, txen_wr = 1'b0, txen_wdata = 1'b0, tx_go = 1'b0, tmr_uflow = 1'b0;
   logic start_det, stop_det, bus_busy, arb_lost, txen, tx_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2c_line_monitor dut_i (
      .clk(clk), .rst_n(rst_n), .scl_line(scl_line), .sda_line(sda_line),
      .i2c_mode(i2c_mode), .coll_sel(coll_sel), .abt_gran(abt_gran),
      .autoclr_en(autoclr_en), .tx_trig_sel(tx_trig_sel), .xfer_clk(xfer_clk),
      .drv_bit(drv_bit), .byte_done(byte_done), .arb_clr(arb_clr),
      .txen_wr(txen_wr), .txen_wdata(txen_wdata), .tx_go(tx_go),
      .tmr_uflow(tmr_uflow), .start_det(start_det), .stop_det(stop_det),
      .bus_busy(bus_busy), .arb_lost(arb_lost), .txen(txen), .tx_start(tx_start)
   );

   // {scl, sda, expected bus_busy}; each entry changes one line
   localparam logic [2:0] LINE_VEC [0:10] = '{
      3'b110, 3'b101, 3'b001, 3'b011, 3'b111, 3'b101,
      3'b110, 3'b010, 3'b000, 3'b100, 3'b110
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic xclk_pulse();
      xfer_clk = 1'b1;
      tick(1);
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      tick(2);
      // R10 reset state
      chk("R10 bus_busy", bus_busy, 1'b0);
      chk("R10 arb_lost", arb_lost, 1'b0);
      chk("R10 txen", txen, 1'b0);
      chk("R10 tx_start", tx_start, 1'b0);
      chk("R10 start_det", start_det, 1'b0);
      chk("R10 stop_det", stop_det, 1'b0);
      rst_n = 1'b1;
      i2c_mode = 1'b1;
      tick(4);

      // R1 line sequence table
      for (int i = 0; i < 11; i++) begin
         scl_line = LINE_VEC[i][2];
         sda_line = LINE_VEC[i][1];
         tick(4);
         chk($sformatf("R1 vec%0d bus_busy", i), bus_busy, LINE_VEC[i][0]);
      end

      // R1 exact latency of START
      sda_line = 1'b0;
      tick(2);
      chk("R1 start_det after sync", start_det, 1'b1);
      chk("R1 busy not yet", bus_busy, 1'b0);
      tick(1);
      chk("R1 busy third edge", bus_busy, 1'b1);
      sda_line = 1'b1;
      tick(4);
      chk("R1 stop clears", bus_busy, 1'b0);

      // R9 mode off ignores START
      i2c_mode = 1'b0;
      sda_line = 1'b0;
      tick(2);
      chk("R9 no start pulse", start_det, 1'b0);
      tick(2);
      chk("R9 busy held low", bus_busy, 1'b0);
      sda_line = 1'b1;
      tick(4);

      // collision setup: scl low, data held low
      i2c_mode = 1'b1;
      scl_line = 1'b0;
      tick(2);
      sda_line = 1'b0;
      tick(4);
      txen_wr = 1'b1; txen_wdata = 1'b1;
      tick(1);
      txen_wr = 1'b0;
      chk("R7 txen written", txen, 1'b1);
      autoclr_en = 1'b1;

      // R2 no mismatch
      drv_bit = 1'b0;
      xclk_pulse();
      chk("R2 no mismatch arb_lost", arb_lost, 1'b0);
      xfer_clk = 1'b0; tick(1);
      chk("R2 no mismatch txen kept", txen, 1'b1);

      // R4 per-bit collision, R7 auto clear
      drv_bit = 1'b1;
      xclk_pulse();
      chk("R4 per-bit flag set", arb_lost, 1'b1);
      chk("R7 autoclear txen", txen, 1'b0);
      xfer_clk = 1'b0; tick(1);

      // R6 clear
      arb_clr = 1'b1; tick(1); arb_clr = 1'b0;
      chk("R6 clear", arb_lost, 1'b0);

      // R7 auto clear disabled
      autoclr_en = 1'b0;
      txen_wr = 1'b1; txen_wdata = 1'b1; tick(1); txen_wr = 1'b0;
      xclk_pulse();
      chk("R7 no autoclear txen kept", txen, 1'b1);
      chk("R4 flag set again", arb_lost, 1'b1);
      xfer_clk = 1'b0; tick(1);

      // R6 set wins over clear
      arb_clr = 1'b1;
      xclk_pulse();
      arb_clr = 1'b0;
      chk("R6 set wins", arb_lost, 1'b1);
      xfer_clk = 1'b0;
      arb_clr = 1'b1; tick(1); arb_clr = 1'b0;
      chk("R6 clear again", arb_lost, 1'b0);

      // R3 data-fall sampling ignores transfer clock
      coll_sel = 1'b1;
      xclk_pulse();
      xfer_clk = 1'b0; tick(1);
      chk("R3 xclk ignored", arb_lost, 1'b0);
      sda_line = 1'b1;
      tick(4);
      sda_line = 1'b0;
      tick(2);
      chk("R3 before fall sample", arb_lost, 1'b0);
      tick(1);
      chk("R3 data fall sample", arb_lost, 1'b1);
      arb_clr = 1'b1; tick(1); arb_clr = 1'b0;
      coll_sel = 1'b0;

      // R5 per-byte
      abt_gran = 1'b1;
      xclk_pulse();
      xfer_clk = 1'b0; tick(3);
      chk("R5 held until byte end", arb_lost, 1'b0);
      byte_done = 1'b1; tick(1); byte_done = 1'b0;
      chk("R5 set at byte end", arb_lost, 1'b1);
      arb_clr = 1'b1; tick(1); arb_clr = 1'b0;
      byte_done = 1'b1; tick(1); byte_done = 1'b0;
      chk("R5 pending consumed", arb_lost, 1'b0);
      abt_gran = 1'b0;

      // R7 auto clear beats same-cycle write
      autoclr_en = 1'b1;
      txen_wr = 1'b1; txen_wdata = 1'b1;
      xclk_pulse();
      txen_wr = 1'b0; xfer_clk = 1'b0;
      chk("R7 autoclear over write", txen, 1'b0);
      drv_bit = 1'b0;
      arb_clr = 1'b1; txen_wr = 1'b1; txen_wdata = 1'b1;
      tick(1);
      arb_clr = 1'b0; txen_wr = 1'b0;

      // R8 trigger selection
      tx_trig_sel = 1'b0;
      tx_go = 1'b1; tick(1); tx_go = 1'b0;
      chk("R8 sw trigger pulse", tx_start, 1'b1);
      tick(1);
      chk("R8 pulse one cycle", tx_start, 1'b0);
      tmr_uflow = 1'b1; tick(1); tmr_uflow = 1'b0;
      chk("R8 timer ignored in sw mode", tx_start, 1'b0);
      tx_trig_sel = 1'b1;
      tmr_uflow = 1'b1; tick(1); tmr_uflow = 1'b0;
      chk("R8 timer trigger pulse", tx_start, 1'b1);
      tx_go = 1'b1; tick(1); tx_go = 1'b0;
      chk("R8 sw ignored in timer mode", tx_start, 1'b0);
      txen_wr = 1'b1; txen_wdata = 1'b0; tick(1); txen_wr = 1'b0;
      tmr_uflow = 1'b1; tick(1); tmr_uflow = 1'b0;
      chk("R8 no pulse with txen low", tx_start, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule